// File: doc/BRIEF.md
# Configurable CRC32 Checksum Unit

This block keeps a running 32-bit cyclic redundancy remainder over a stream of data items delivered by a DMA data path. A small register write port sets everything that defines the checksum while the block runs. That covers the generator polynomial, the starting value of the shift register, a mask XORed into each incoming item and a mask XORed into the result. It also covers two reflection switches, one that reverses the bit order of each incoming item and one that reverses the finished remainder. Because all of these are run-time settings, the same hardware can produce reflected and non-reflected CRC-32 variants.

Each cycle in which the input is valid, the block folds one item into the shift register. The item is either a byte, taken from the low eight bits of the data word, or a full 32-bit word. A start pulse discards the running state and reloads the programmed seed. The result output always shows the current remainder after the output reflection and output XOR.

Top module: `crc32u_top`

## Requirements
- R1: After a synchronous active-low reset, every configuration field and the shift register are zero, so `crc_result` reads 0.
- R2: A write with `cfg_we` high updates the addressed field at the next clock edge. The addresses are 0 for control (bit 0 is input reflect, bit 1 is output reflect), 1 for the polynomial, 2 for the seed, 3 for the input XOR mask and 4 for the output XOR mask.
- R3: A `start` pulse without `in_valid` loads the shift register with the seed. With both output transforms off, `crc_result` then equals the seed one cycle later.
- R4: With `in_size`=0, the low 8 bits of `in_data` are shifted in MSB first in one cycle. For each bit, feedback = state[31] XOR bit, and the new state is (state<<1) XOR (feedback ? polynomial : 0).
- R5: With `in_size`=1, all 32 bits of `in_data` are shifted in MSB first in one cycle. Feeding two words gives the same remainder as feeding the eight equivalent bytes under the reflected setting.
- R6: With input reflect set, each item is bit-reversed within its own width (8 or 32 bits) before it is shifted in.
- R7: The input XOR mask, cut to the item width, is applied before the input reflection.
- R8: The output is formed by first reversing the state when output reflect is set and then XORing the output mask. Standard reflected CRC-32 over the ASCII digits "123456789" gives 0xCBF43926, and the non-reflected variant with zero output mask gives 0x0376E6E7.
- R9: When `start` and `in_valid` occur in the same cycle, the item is folded into the seed rather than into the previous state.
- R10: With neither `in_valid` nor `start`, the shift register holds its value.
- R11: Writing the seed field does not alter the running remainder until the next `start`.
- R12: A write to an address above 4 changes no field.
- R13: In byte mode, bits 31:8 of `in_data` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration field address |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | Reload the shift register from the seed |
| in_valid | input | 1 | Data item present this cycle |
| in_size | input | 1 | Item width: 0 = byte, 1 = 32-bit word |
| in_data | input | 32 | Data item, byte in bits 7:0 |
| crc_result | output | 32 | Remainder after output reflection and XOR |

## Verification
The bench builds the block with its default parameters: a 32-bit remainder, a 32-bit data word and an 8-bit byte item. With these values both branches of the per-width step generator are instantiated, so byte and word folding can be cross-checked against each other over the same message. The 32-bit remainder width also makes published CRC-32 check values usable as fixed anchors next to the bench's bitwise model. Asymmetric XOR masks combined with reflection expose any swap in the order of the transforms.

// File: rtl/crc32u_pkg.sv
// Package: shared widths, configuration field addresses and the config
// record passed from the register block to the datapath.
package crc32u_pkg;
    localparam int CRC_W  = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_POLY = 3'd1;
    localparam logic [ADDR_W-1:0] A_SEED = 3'd2;
    localparam logic [ADDR_W-1:0] A_IXOR = 3'd3;
    localparam logic [ADDR_W-1:0] A_OXOR = 3'd4;

    localparam int CTRL_IREF_BIT = 0;
    localparam int CTRL_OREF_BIT = 1;

    typedef struct packed {
        logic             in_reflect;
        logic             out_reflect;
        logic [CRC_W-1:0] poly;
        logic [CRC_W-1:0] seed;
        logic [CRC_W-1:0] in_xor;
        logic [CRC_W-1:0] out_xor;
    } crc_cfg_t;
endpackage

// File: rtl/crc32u_cfg.sv
// Module: crc32u_cfg
// Holds the run-time configuration fields written through a simple
// address/data port. Assumes one write per cycle; unmapped addresses
// are dropped. Synchronous active-low reset clears every field.
module crc32u_cfg
    import crc32u_pkg::*;
#(
    parameter int WDATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [WDATA_W-1:0] cfg_wdata,
    output crc_cfg_t           cfg_o
);
    crc_cfg_t cfg_q;

    // Purpose: capture the addressed field on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_CTRL: begin
                    cfg_q.in_reflect  <= cfg_wdata[CTRL_IREF_BIT];
                    cfg_q.out_reflect <= cfg_wdata[CTRL_OREF_BIT];
                end
                A_POLY:  cfg_q.poly    <= cfg_wdata[CRC_W-1:0];
                A_SEED:  cfg_q.seed    <= cfg_wdata[CRC_W-1:0];
                A_IXOR:  cfg_q.in_xor  <= cfg_wdata[CRC_W-1:0];
                A_OXOR:  cfg_q.out_xor <= cfg_wdata[CRC_W-1:0];
                default: cfg_q <= cfg_q;
            endcase
        end
    end

    assign cfg_o = cfg_q;

    // R2: a polynomial write lands at the next edge.
    a_r2_poly_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_POLY) |=> (cfg_o.poly == $past(cfg_wdata[CRC_W-1:0])));

    // R12: unmapped addresses and idle cycles leave every field unchanged.
    a_r12_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we || cfg_addr > A_OXOR) |=> $stable(cfg_o));
endmodule

// File: rtl/crc32u_step.sv
// Module: crc32u_step
// Combinational fold of one ITEM_W-bit item into the CRC state: input XOR,
// optional bit reversal within the item, then ITEM_W MSB-first Galois
// shifts. Assumes ITEM_W <= CRC_W.
module crc32u_step
    import crc32u_pkg::*;
#(
    parameter int ITEM_W = 8
) (
    input  logic [CRC_W-1:0]  state_i,
    input  logic [CRC_W-1:0]  poly_i,
    input  logic [ITEM_W-1:0] item_i,
    input  logic [ITEM_W-1:0] xor_i,
    input  logic              reflect_i,
    output logic [CRC_W-1:0]  state_o
);
    logic [ITEM_W-1:0] masked;
    logic [ITEM_W-1:0] ordered;
    logic [CRC_W-1:0]  acc;
    logic              fb;

    // Purpose: mask the item, then optionally mirror its bit order.
    always_comb begin
        masked = item_i ^ xor_i;
        for (int i = 0; i < ITEM_W; i++) begin
            ordered[i] = reflect_i ? masked[ITEM_W-1-i] : masked[i];
        end
    end

    // Purpose: shift the item into the state one bit at a time, MSB first.
    always_comb begin
        acc = state_i;
        fb  = 1'b0;
        for (int k = 0; k < ITEM_W; k++) begin
            fb  = acc[CRC_W-1] ^ ordered[ITEM_W-1-k];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? poly_i : '0);
        end
        state_o = acc;
    end
endmodule

// File: rtl/crc32u_outx.sv
// Module: crc32u_outx
// Output transform: optional full-width reversal of the state followed by
// the output XOR mask. Purely combinational.
module crc32u_outx
    import crc32u_pkg::*;
(
    input  logic [CRC_W-1:0] state_i,
    input  logic             reflect_i,
    input  logic [CRC_W-1:0] xor_i,
    output logic [CRC_W-1:0] result_o
);
    logic [CRC_W-1:0] mirrored;

    // Purpose: mirror the state when requested, then apply the mask.
    always_comb begin
        for (int i = 0; i < CRC_W; i++) begin
            mirrored[i] = state_i[CRC_W-1-i];
        end
        result_o = (reflect_i ? mirrored : state_i) ^ xor_i;
    end
endmodule

// File: rtl/crc32u_top.sv
// Module: crc32u_top
// Running CRC engine. Configuration comes from crc32u_cfg; one byte or one
// word is folded per valid cycle by a per-width step instance chosen by
// in_size. start reloads the seed; with in_valid in the same cycle the
// item is folded into the seed. Assumes BYTE_W <= DATA_W == CRC_W.
module crc32u_top
    import crc32u_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic              in_valid,
    input  logic              in_size,
    input  logic [DATA_W-1:0] in_data,
    output logic [CRC_W-1:0]  crc_result
);
    localparam int N_WIDTHS = 2;

    crc_cfg_t         cfg;
    logic [CRC_W-1:0] lfsr_q;
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] step_out [N_WIDTHS];
    logic [CRC_W-1:0] folded;

    crc32u_cfg #(.WDATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg)
    );

    // Purpose: pick the state the item is folded into.
    assign base = start ? cfg.seed : lfsr_q;

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        localparam int WID = (g == 0) ? BYTE_W : DATA_W;
        crc32u_step #(.ITEM_W(WID)) u_step (
            .state_i   (base),
            .poly_i    (cfg.poly),
            .item_i    (in_data[WID-1:0]),
            .xor_i     (cfg.in_xor[WID-1:0]),
            .reflect_i (cfg.in_reflect),
            .state_o   (step_out[g])
        );
    end

    // Purpose: select the fold result for the requested item width.
    assign folded = in_size ? step_out[1] : step_out[0];

    // Purpose: advance, reload or hold the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= '0;
        end else if (in_valid) begin
            lfsr_q <= folded;
        end else if (start) begin
            lfsr_q <= cfg.seed;
        end
    end

    crc32u_outx u_outx (
        .state_i   (lfsr_q),
        .reflect_i (cfg.out_reflect),
        .xor_i     (cfg.out_xor),
        .result_o  (crc_result)
    );

    // R3: a bare start leaves the seed in the shift register.
    a_r3_start_loads_seed: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !in_valid) |=> (lfsr_q == $past(cfg.seed)));

    // R10: no activity means the remainder holds.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !in_valid) |=> $stable(lfsr_q));

    // R8: with both output transforms off the result is the raw state.
    a_r8_plain_output: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.out_reflect && cfg.out_xor == '0) |-> (crc_result == lfsr_q));
endmodule

// File: tb/tb_crc32u_top.sv
`timescale 1ns/1ps
module tb_crc32u_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        start;
    logic        in_valid;
    logic        in_size;
    logic [31:0] in_data;
    logic [31:0] crc_result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Shadow configuration and model state
    bit          s_iref, s_oref;
    logic [31:0] s_poly, s_seed, s_ixor, s_oxor, m_state;

    crc32u_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .in_valid(in_valid),
        .in_size(in_size), .in_data(in_data), .crc_result(crc_result)
    );

    always #10 clk = ~clk;

    // Vectors: {start, size, data}; "123456789" bytes then "12345678" as two words
    localparam logic [33:0] VEC [11] = '{
        {1'b1, 1'b0, 32'h0000_0031}, {1'b0, 1'b0, 32'h0000_0032},
        {1'b0, 1'b0, 32'h0000_0033}, {1'b0, 1'b0, 32'h0000_0034},
        {1'b0, 1'b0, 32'h0000_0035}, {1'b0, 1'b0, 32'h0000_0036},
        {1'b0, 1'b0, 32'h0000_0037}, {1'b0, 1'b0, 32'h0000_0038},
        {1'b0, 1'b0, 32'h0000_0039},
        {1'b1, 1'b1, 32'h3433_3231}, {1'b0, 1'b1, 32'h3837_3635}
    };

    function automatic logic [31:0] m_step(input logic [31:0] st, input logic [31:0] d,
                                           input bit sz);
        int w = sz ? 32 : 8;
        logic [31:0] x = (d ^ s_ixor) & (sz ? 32'hFFFF_FFFF : 32'h0000_00FF);
        logic b;
        for (int k = 0; k < w; k++) begin
            b  = s_iref ? x[k] : x[w-1-k];
            if (st[31] ^ b) st = (st << 1) ^ s_poly;
            else            st = st << 1;
        end
        return st;
    endfunction

    function automatic logic [31:0] m_out(input logic [31:0] st);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = s_oref ? st[31-i] : st[i];
        return r ^ s_oxor;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            3'd0: begin s_iref = v[0]; s_oref = v[1]; end
            3'd1: s_poly = v;
            3'd2: s_seed = v;
            3'd3: s_ixor = v;
            3'd4: s_oxor = v;
            default: ;
        endcase
    endtask

    task automatic push(input bit st, input bit vld, input bit sz, input logic [31:0] d);
        @(negedge clk);
        start = st; in_valid = vld; in_size = sz; in_data = d;
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        if (st) m_state = s_seed;
        if (vld) m_state = m_step(m_state, d, sz);
    endtask

    task automatic cfg_std();
        wr(3'd0, 32'h3); wr(3'd1, 32'h04C1_1DB7); wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0); wr(3'd4, 32'hFFFF_FFFF);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        s_iref = 0; s_oref = 0; s_poly = 0; s_seed = 0; s_ixor = 0; s_oxor = 0;
        m_state = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] held, ref8;
        rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        start = 0; in_valid = 0; in_size = 0; in_data = 0;
        do_reset();
        check("R1 reset result", crc_result, 32'h0);

        // R3: bare start loads seed, plain output
        wr(3'd2, 32'hA5A5_0F0F);
        push(1'b1, 1'b0, 1'b0, 32'h0);
        check("R3 start loads seed", crc_result, 32'hA5A5_0F0F);

        // R2 R4: non-reflected variant, known check value
        wr(3'd1, 32'h04C1_1DB7); wr(3'd2, 32'hFFFF_FFFF);
        push(1'b1, 1'b0, 1'b0, 32'h0);
        for (int c = 0; c < 9; c++) push(1'b0, 1'b1, 1'b0, 32'h31 + c);
        check("R4 R2 msb-first bytes", crc_result, 32'h0376_E6E7);

        // R10: idle cycles hold
        held = crc_result;
        repeat (3) @(negedge clk);
        check("R10 idle hold", crc_result, held);

        // R11: seed write does not touch running state
        wr(3'd2, 32'h1234_5678);
        check("R11 seed write no effect", crc_result, held);
        push(1'b1, 1'b0, 1'b0, 32'h0);
        check("R11 new seed after start", crc_result, 32'h1234_5678);

        // Table walk under reflected CRC-32 settings (R6 R5 R8)
        cfg_std();
        for (int i = 0; i < 11; i++) begin
            push(VEC[i][33], 1'b1, VEC[i][32], VEC[i][31:0]);
            check("R6 table step", crc_result, m_out(m_state));
            if (i == 8) check("R8 reflected check value", crc_result, 32'hCBF4_3926);
        end
        ref8 = s_seed;
        for (int c = 0; c < 8; c++) ref8 = m_step(ref8, 32'h31 + c, 1'b0);
        check("R5 words equal bytes", crc_result, m_out(ref8));

        // R9: start and valid together fold into the seed
        push(1'b0, 1'b1, 1'b0, 32'h55);
        push(1'b1, 1'b1, 1'b0, 32'h31);
        check("R9 start with data", crc_result, m_out(m_step(32'hFFFF_FFFF, 32'h31, 1'b0)));

        // R7: input XOR before reflection, asymmetric mask
        wr(3'd3, 32'h0000_0001);
        push(1'b1, 1'b1, 1'b0, 32'h80);
        check("R7 xor then reflect byte", crc_result, m_out(m_state));
        push(1'b0, 1'b1, 1'b1, 32'hC000_0010);
        check("R7 xor then reflect word", crc_result, m_out(m_state));
        wr(3'd3, 32'h0);

        // R8: reflect then xor with asymmetric output mask
        wr(3'd4, 32'h0000_0001);
        check("R8 reflect then xor", crc_result, m_out(m_state));

        // R13: upper bits ignored in byte mode
        push(1'b1, 1'b1, 1'b0, 32'hDEAD_BE42);
        check("R13 byte upper ignored", crc_result,
              m_out(m_step(32'hFFFF_FFFF, 32'h42, 1'b0)));

        // R12: unmapped writes change nothing
        wr(3'd5, 32'h0BAD_F00D); wr(3'd7, 32'hFFFF_FFFF);
        push(1'b1, 1'b1, 1'b0, 32'h37);
        check("R12 unmapped ignored", crc_result, m_out(m_state));

        // R1: reset mid-run clears configuration and state
        do_reset();
        check("R1 mid-run reset", crc_result, 32'h0);
        push(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF);
        check("R1 config cleared", crc_result, 32'h0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule